// File: doc/BRIEF.md
# Banked CPU Register File

This block is the register storage of an 8-bit processor core. It holds two full banks of six general-purpose bytes, two accumulator/flag pairs, and the special-purpose registers: two 16-bit index bases, the stack pointer, the program counter, an interrupt vector page byte and a refresh byte. Altogether that is 208 bits. Two read ports and one write port each reach a register either as a single byte or as a 16-bit pair. The accumulator and flag bytes also have dedicated read outputs and write inputs, so the datapath can use them without taking up a read port.

Two bank-select flip-flops choose which copy is active. One selects the accumulator/flag pair. The other selects all six general-purpose bytes together. An exchange command inverts its flip-flop in one cycle and copies no data, so switching context for a fast service routine costs one clock. Instruction decode, the ALU and flag computation are outside this block. They supply the select codes and write data.

Top module: `banked_regfile`

## Requirements
- R1: When `rst` is high at a rising edge, every storage byte clears to zero and both bank-select flip-flops choose bank 0. All reads and `acc_q`/`flg_q` then return zero.
- R2: A byte access (`*_wide`=0) decodes its 3-bit code as follows: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L of the active general-purpose bank, 6=vector page byte, 7=refresh byte. A byte read returns the value on bits 7:0 of the read bus, with bits 15:8 at zero. A byte write takes its data from `wr_data[7:0]`.
- R3: A 16-bit access (`*_wide`=1) decodes its code as follows: 0=BC, 1=DE, 2=HL, 3=active accumulator:flag, 4=index X, 5=index Y, 6=stack pointer, 7=program counter. For pairs, the first-named byte (B, D, H, accumulator) is bits 15:8 and the second is bits 7:0.
- R4: Reads are combinational. A read in the same cycle as a write to the same register returns the old value. The new value appears on the read bus in the cycle after the write's clock edge.
- R5: `acc_we` and `flg_we` write `acc_d`/`flg_d` into the active accumulator/flag pair, and `acc_q`/`flg_q` show the active pair. If a 16-bit write to code 3 hits the same byte in the same cycle, the dedicated input wins for that byte.
- R6: `xchg_af` inverts the accumulator/flag bank select at the clock edge. Both pairs keep their contents, and the general-purpose bank is unaffected.
- R7: `xchg_gp` inverts the general-purpose bank select at the clock edge, switching B through L together. The accumulator/flag select and all special-purpose registers are unaffected.
- R8: A write in the same cycle as an exchange lands in the bank that was active before the exchange.
- R9: The two read ports decode independently. Both may address any register, including the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xchg_af | input | 1 | Invert accumulator/flag bank select |
| xchg_gp | input | 1 | Invert general-purpose bank select |
| ra_wide | input | 1 | Read port A: 1 = 16-bit access |
| ra_code | input | 3 | Read port A register code |
| ra_data | output | 16 | Read port A data |
| rb_wide | input | 1 | Read port B: 1 = 16-bit access |
| rb_code | input | 3 | Read port B register code |
| rb_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_wide | input | 1 | Write port: 1 = 16-bit access |
| wr_code | input | 3 | Write port register code |
| wr_data | input | 16 | Write data |
| acc_we | input | 1 | Accumulator write enable |
| acc_d | input | 8 | Accumulator write data |
| flg_we | input | 1 | Flag write enable |
| flg_d | input | 8 | Flag write data |
| acc_q | output | 8 | Active accumulator |
| flg_q | output | 8 | Active flags |

## Verification
Read data has zero cycles of latency, so the bench drives each vector on the falling edge and compares both read buses and the accumulator/flag outputs about one time unit later, before the next rising edge. Writes, dedicated accumulator/flag writes and both exchanges take effect at that rising edge. The bench's reference model applies them only after the edge, so every comparison in the following cycle sees the post-edge state, and every same-cycle comparison sees the pre-edge state. Directed vectors place writes and exchanges in the same cycle, and read a register in the same cycle it is written.

// File: rtl/brf_pkg.sv
package brf_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int GP_N     = 6;
    localparam int SPEC_N   = 4;
    localparam int BANKS    = 2;
    localparam int CODE_W   = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // byte-access codes
    typedef enum logic [CODE_W-1:0] {
        BC_B = 3'd0, BC_C = 3'd1, BC_D = 3'd2, BC_E = 3'd3,
        BC_H = 3'd4, BC_L = 3'd5, BC_VEC = 3'd6, BC_RFS = 3'd7
    } byte_code_e;

    // low two bits of a wide code with bit 2 clear
    localparam logic [1:0] PAIR_ACCF = 2'd3;

    typedef struct packed {
        logic                 wide;
        logic [CODE_W-1:0]    code;
    } sel_t;

    // index of the high byte of general pair p
    function automatic logic [2:0] pair_hi(input logic [1:0] p);
        return {p, 1'b0};
    endfunction

    function automatic logic [2:0] pair_lo(input logic [1:0] p);
        return {p, 1'b1};
    endfunction

    function automatic logic is_gp_byte(input logic [CODE_W-1:0] c);
        return c < CODE_W'(GP_N);
    endfunction
endpackage

// File: rtl/brf_gp_bank.sv
module brf_gp_bank
    import brf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [GP_N-1:0]              we,
    input  logic [GP_N-1:0][BYTE_W-1:0]  wd,
    output logic [GP_N-1:0][BYTE_W-1:0]  q
);
    for (genvar k = 0; k < GP_N; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                q[k] <= '0;
            else if (we[k])
                q[k] <= wd[k];
        end
    end
endmodule

// File: rtl/brf_af_bank.sv
module brf_af_bank
    import brf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  a_we,
    input  byte_t a_wd,
    input  logic  f_we,
    input  byte_t f_wd,
    output byte_t a_q,
    output byte_t f_q
);
    byte_t a_r [BANKS];
    byte_t f_r [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                a_r[b] <= '0;
                f_r[b] <= '0;
            end else if (sel == 1'(b)) begin
                if (a_we) a_r[b] <= a_wd;
                if (f_we) f_r[b] <= f_wd;
            end
        end
    end

    assign a_q = a_r[sel];
    assign f_q = f_r[sel];
endmodule

// File: rtl/brf_special.sv
module brf_special
    import brf_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SPEC_N-1:0]             w_we,
    input  word_t                         w_wd,
    input  logic                          vec_we,
    input  logic                          rfs_we,
    input  byte_t                         b_wd,
    output logic [SPEC_N-1:0][WORD_W-1:0] w_q,
    output byte_t                         vec_q,
    output byte_t                         rfs_q
);
    for (genvar k = 0; k < SPEC_N; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                w_q[k] <= '0;
            else if (w_we[k])
                w_q[k] <= w_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            rfs_q <= '0;
        end else begin
            if (vec_we) vec_q <= b_wd;
            if (rfs_we) rfs_q <= b_wd;
        end
    end
endmodule

// File: rtl/brf_rd_mux.sv
module brf_rd_mux
    import brf_pkg::*;
(
    input  sel_t                          sel,
    input  logic [GP_N-1:0][BYTE_W-1:0]   gp,
    input  byte_t                         a,
    input  byte_t                         f,
    input  logic [SPEC_N-1:0][WORD_W-1:0] spec,
    input  byte_t                         vec,
    input  byte_t                         rfs,
    output word_t                         data
);
    always_comb begin
        data = '0;
        if (!sel.wide) begin
            if (is_gp_byte(sel.code))
                data[BYTE_W-1:0] = gp[sel.code];
            else if (sel.code == BC_VEC)
                data[BYTE_W-1:0] = vec;
            else
                data[BYTE_W-1:0] = rfs;
        end else if (!sel.code[2]) begin
            if (sel.code[1:0] == PAIR_ACCF)
                data = {a, f};
            else
                data = {gp[pair_hi(sel.code[1:0])], gp[pair_lo(sel.code[1:0])]};
        end else begin
            data = spec[sel.code[1:0]];
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xchg_af,
    input  logic        xchg_gp,
    input  logic        ra_wide,
    input  logic [2:0]  ra_code,
    output logic [15:0] ra_data,
    input  logic        rb_wide,
    input  logic [2:0]  rb_code,
    output logic [15:0] rb_data,
    input  logic        wr_en,
    input  logic        wr_wide,
    input  logic [2:0]  wr_code,
    input  logic [15:0] wr_data,
    input  logic        acc_we,
    input  logic [7:0]  acc_d,
    input  logic        flg_we,
    input  logic [7:0]  flg_d,
    output logic [7:0]  acc_q,
    output logic [7:0]  flg_q
);
    logic gp_sel, af_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            gp_sel <= 1'b0;
            af_sel <= 1'b0;
        end else begin
            if (xchg_gp) gp_sel <= ~gp_sel;
            if (xchg_af) af_sel <= ~af_sel;
        end
    end

    // write decode
    logic [GP_N-1:0]              gp_we;
    logic [GP_N-1:0][BYTE_W-1:0]  gp_wd;
    logic [SPEC_N-1:0]            sp_we;
    logic                         vec_we, rfs_we;
    logic                         a_we, f_we;
    byte_t                        a_wd, f_wd;

    always_comb begin
        gp_we  = '0;
        sp_we  = '0;
        vec_we = 1'b0;
        rfs_we = 1'b0;
        a_we   = acc_we;
        f_we   = flg_we;
        a_wd   = acc_d;
        f_wd   = flg_d;
        for (int k = 0; k < GP_N; k++)
            gp_wd[k] = (wr_wide && !k[0]) ? wr_data[WORD_W-1:BYTE_W] : wr_data[BYTE_W-1:0];
        if (wr_en) begin
            if (!wr_wide) begin
                if (is_gp_byte(wr_code))
                    gp_we[wr_code] = 1'b1;
                else if (wr_code == BC_VEC)
                    vec_we = 1'b1;
                else
                    rfs_we = 1'b1;
            end else if (!wr_code[2]) begin
                if (wr_code[1:0] == PAIR_ACCF) begin
                    if (!acc_we) begin
                        a_we = 1'b1;
                        a_wd = wr_data[WORD_W-1:BYTE_W];
                    end
                    if (!flg_we) begin
                        f_we = 1'b1;
                        f_wd = wr_data[BYTE_W-1:0];
                    end
                end else begin
                    gp_we[pair_hi(wr_code[1:0])] = 1'b1;
                    gp_we[pair_lo(wr_code[1:0])] = 1'b1;
                end
            end else begin
                sp_we[wr_code[1:0]] = 1'b1;
            end
        end
    end

    // general-purpose banks
    logic [GP_N-1:0][BYTE_W-1:0] gp_bank_q [BANKS];
    logic [GP_N-1:0][BYTE_W-1:0] gp_act;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        brf_gp_bank u_bank (
            .clk (clk),
            .rst (rst),
            .we  ((gp_sel == 1'(b)) ? gp_we : '0),
            .wd  (gp_wd),
            .q   (gp_bank_q[b])
        );
    end

    assign gp_act = gp_bank_q[gp_sel];

    brf_af_bank u_af (
        .clk  (clk),
        .rst  (rst),
        .sel  (af_sel),
        .a_we (a_we),
        .a_wd (a_wd),
        .f_we (f_we),
        .f_wd (f_wd),
        .a_q  (acc_q),
        .f_q  (flg_q)
    );

    logic [SPEC_N-1:0][WORD_W-1:0] sp_q;
    byte_t                         vec_q, rfs_q;

    brf_special u_spec (
        .clk    (clk),
        .rst    (rst),
        .w_we   (sp_we),
        .w_wd   (wr_data),
        .vec_we (vec_we),
        .rfs_we (rfs_we),
        .b_wd   (wr_data[BYTE_W-1:0]),
        .w_q    (sp_q),
        .vec_q  (vec_q),
        .rfs_q  (rfs_q)
    );

    sel_t sel_a, sel_b;
    assign sel_a = '{wide: ra_wide, code: ra_code};
    assign sel_b = '{wide: rb_wide, code: rb_code};

    brf_rd_mux u_rd_a (
        .sel (sel_a), .gp (gp_act), .a (acc_q), .f (flg_q),
        .spec (sp_q), .vec (vec_q), .rfs (rfs_q), .data (ra_data)
    );

    brf_rd_mux u_rd_b (
        .sel (sel_b), .gp (gp_act), .a (acc_q), .f (flg_q),
        .spec (sp_q), .vec (vec_q), .rfs (rfs_q), .data (rb_data)
    );
endmodule

// File: rtl/brf_checker.sv
module brf_checker (
    input logic        clk,
    input logic        rst,
    input logic        xchg_af,
    input logic        xchg_gp,
    input logic        ra_wide,
    input logic [2:0]  ra_code,
    input logic [15:0] ra_data,
    input logic        wr_en,
    input logic        wr_wide,
    input logic [2:0]  wr_code,
    input logic [15:0] wr_data,
    input logic        acc_we,
    input logic [7:0]  acc_d,
    input logic        flg_we,
    input logic [7:0]  acc_q,
    input logic [7:0]  flg_q
);
    logic af_pair_wr;
    assign af_pair_wr = wr_en && wr_wide && (wr_code == 3'd3);

    // R1: state is zero the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_q == 8'h00 && flg_q == 8'h00));

    // R2: byte reads leave the high half of the bus at zero
    assert_byte_zero_ext_R2: assert property (@(posedge clk) disable iff (rst)
        !ra_wide |-> ra_data[15:8] == 8'h00);

    // R4: a byte write shows up on a matching read in the next cycle
    assert_write_visible_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_wide && !xchg_gp) |=>
        (ra_wide || ra_code != $past(wr_code) || ra_data == {8'h00, $past(wr_data[7:0])}));

    // R5: dedicated accumulator write lands in the active pair
    assert_acc_write_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_we && !xchg_af) |=> acc_q == $past(acc_d));

    // R6: without exchange or write the accumulator/flag outputs hold
    assert_af_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!xchg_af && !acc_we && !flg_we && !af_pair_wr) |=> ($stable(acc_q) && $stable(flg_q)));

    // R7: with no write and no bank swap, a repeated byte read holds
    assert_gp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!xchg_gp && !wr_en && !ra_wide) |=>
        (!($stable(ra_code) && !ra_wide) || $stable(ra_data)));
endmodule

bind banked_regfile brf_checker u_brf_checker (
    .clk     (clk),
    .rst     (rst),
    .xchg_af (xchg_af),
    .xchg_gp (xchg_gp),
    .ra_wide (ra_wide),
    .ra_code (ra_code),
    .ra_data (ra_data),
    .wr_en   (wr_en),
    .wr_wide (wr_wide),
    .wr_code (wr_code),
    .wr_data (wr_data),
    .acc_we  (acc_we),
    .acc_d   (acc_d),
    .flg_we  (flg_we),
    .acc_q   (acc_q),
    .flg_q   (flg_q)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xchg_af = 0, xchg_gp = 0;
    logic        ra_wide = 0, rb_wide = 0;
    logic [2:0]  ra_code = 0, rb_code = 0;
    logic [15:0] ra_data, rb_data;
    logic        wr_en = 0, wr_wide = 0;
    logic [2:0]  wr_code = 0;
    logic [15:0] wr_data = 0;
    logic        acc_we = 0, flg_we = 0;
    logic [7:0]  acc_d = 0, flg_d = 0;
    logic [7:0]  acc_q, flg_q;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst(rst), .xchg_af(xchg_af), .xchg_gp(xchg_gp),
        .ra_wide(ra_wide), .ra_code(ra_code), .ra_data(ra_data),
        .rb_wide(rb_wide), .rb_code(rb_code), .rb_data(rb_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_code(wr_code), .wr_data(wr_data),
        .acc_we(acc_we), .acc_d(acc_d), .flg_we(flg_we), .flg_d(flg_d),
        .acc_q(acc_q), .flg_q(flg_q)
    );

    // reference model
    logic [7:0]  m_gp [2][6];
    logic [7:0]  m_a [2];
    logic [7:0]  m_f [2];
    logic [15:0] m_sp [4];
    logic [7:0]  m_vec, m_rfs;
    logic        m_gs, m_as;

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 6; k++) m_gp[b][k] = 8'h00;
            m_a[b] = 8'h00;
            m_f[b] = 8'h00;
        end
        for (int k = 0; k < 4; k++) m_sp[k] = 16'h0000;
        m_vec = 8'h00; m_rfs = 8'h00; m_gs = 1'b0; m_as = 1'b0;
    endtask

    function automatic logic [15:0] exp_read(input logic wide, input logic [2:0] code);
        if (!wide) begin
            if (code < 3'd6) return {8'h00, m_gp[m_gs][code]};
            if (code == 3'd6) return {8'h00, m_vec};
            return {8'h00, m_rfs};
        end
        if (!code[2]) begin
            if (code[1:0] == 2'd3) return {m_a[m_as], m_f[m_as]};
            return {m_gp[m_gs][{code[1:0], 1'b0}], m_gp[m_gs][{code[1:0], 1'b1}]};
        end
        return m_sp[code[1:0]];
    endfunction

    task automatic model_step();
        if (wr_en) begin
            if (!wr_wide) begin
                if (wr_code < 3'd6) m_gp[m_gs][wr_code] = wr_data[7:0];
                else if (wr_code == 3'd6) m_vec = wr_data[7:0];
                else m_rfs = wr_data[7:0];
            end else if (!wr_code[2]) begin
                if (wr_code[1:0] == 2'd3) begin
                    if (!acc_we) m_a[m_as] = wr_data[15:8];
                    if (!flg_we) m_f[m_as] = wr_data[7:0];
                end else begin
                    m_gp[m_gs][{wr_code[1:0], 1'b0}] = wr_data[15:8];
                    m_gp[m_gs][{wr_code[1:0], 1'b1}] = wr_data[7:0];
                end
            end else begin
                m_sp[wr_code[1:0]] = wr_data;
            end
        end
        if (acc_we) m_a[m_as] = acc_d;
        if (flg_we) m_f[m_as] = flg_d;
        if (xchg_gp) m_gs = ~m_gs;
        if (xchg_af) m_as = ~m_as;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at falling edge, compare, then advance model at rising edge
    task automatic cycle(input string tag,
                         input logic xa, input logic xg,
                         input logic aw, input logic [2:0] ac,
                         input logic bw, input logic [2:0] bc,
                         input logic we, input logic ww, input logic [2:0] wc,
                         input logic [15:0] wd,
                         input logic aen, input logic [7:0] ad,
                         input logic fen, input logic [7:0] fd);
        @(negedge clk);
        xchg_af = xa; xchg_gp = xg;
        ra_wide = aw; ra_code = ac; rb_wide = bw; rb_code = bc;
        wr_en = we; wr_wide = ww; wr_code = wc; wr_data = wd;
        acc_we = aen; acc_d = ad; flg_we = fen; flg_d = fd;
        #1;
        chk(tag != "" ? tag : (aw ? "R3" : "R2"), ra_data, exp_read(aw, ac));
        chk(tag != "" ? tag : "R9", rb_data, exp_read(bw, bc));
        chk(tag != "" ? tag : "R5", {8'h00, acc_q}, {8'h00, m_a[m_as]});
        chk(tag != "" ? tag : "R5", {8'h00, flg_q}, {8'h00, m_f[m_as]});
        @(posedge clk);
        model_step();
    endtask

    task automatic idle_read(input string tag, input logic aw, input logic [2:0] ac,
                             input logic bw, input logic [2:0] bc);
        cycle(tag, 0, 0, aw, ac, bw, bc, 0, 0, 3'd0, 16'h0, 0, 8'h0, 0, 8'h0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset
        for (int c = 0; c < 8; c++) idle_read("R1", 0, 3'(c), 1, 3'(c));

        // R4: same-cycle read of a written register returns the old value
        cycle("R4", 0, 0, 0, 3'd0, 1, 3'd0, 1, 0, 3'd0, 16'h00A5, 0, 8'h0, 0, 8'h0);
        idle_read("R4", 0, 3'd0, 1, 3'd0);

        // R3: pair byte order and special words
        cycle("R3", 0, 0, 1, 3'd1, 0, 3'd2, 1, 1, 3'd1, 16'h1234, 0, 8'h0, 0, 8'h0);
        cycle("R3", 0, 0, 1, 3'd7, 0, 3'd3, 1, 1, 3'd7, 16'hBEEF, 0, 8'h0, 0, 8'h0);
        idle_read("R3", 1, 3'd7, 0, 3'd3);

        // R5: dedicated accumulator beats the pair write on the same byte
        cycle("R5", 0, 0, 1, 3'd3, 1, 3'd3, 1, 1, 3'd3, 16'h7788, 1, 8'h11, 0, 8'h0);
        idle_read("R5", 1, 3'd3, 1, 3'd3);

        // R7: exchange the general bank, alternate B reads zero, then back
        cycle("R7", 0, 1, 0, 3'd0, 1, 3'd4, 0, 0, 3'd0, 16'h0, 0, 8'h0, 0, 8'h0);
        idle_read("R7", 0, 3'd0, 1, 3'd1);
        // R8: write with exchange lands in pre-exchange (alternate) bank
        cycle("R8", 0, 1, 0, 3'd0, 0, 3'd0, 1, 0, 3'd0, 16'h005A, 0, 8'h0, 0, 8'h0);
        idle_read("R8", 0, 3'd0, 1, 3'd7);
        cycle("R8", 0, 1, 0, 3'd0, 0, 3'd0, 0, 0, 3'd0, 16'h0, 0, 8'h0, 0, 8'h0);
        idle_read("R8", 0, 3'd0, 0, 3'd0);

        // R6: swap the accumulator/flag bank with a write in the same cycle
        cycle("R6", 1, 0, 1, 3'd3, 0, 3'd0, 0, 0, 3'd0, 16'h0, 1, 8'h3C, 1, 8'hC3);
        idle_read("R6", 1, 3'd3, 1, 3'd1);
        cycle("R6", 1, 1, 1, 3'd3, 1, 3'd1, 0, 0, 3'd0, 16'h0, 0, 8'h0, 0, 8'h0);
        idle_read("R6", 1, 3'd3, 0, 3'd0);

        // constrained random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            cycle("",
                  ($urandom % 8) == 0, ($urandom % 8) == 0,
                  1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
                  ($urandom % 3) != 0, 1'($urandom), 3'($urandom), 16'($urandom),
                  ($urandom % 4) == 0, 8'($urandom),
                  ($urandom % 4) == 0, 8'($urandom));
        end

        // R1: reset mid-run clears both banks and selects
        @(negedge clk);
        rst = 1'b1; wr_en = 0; acc_we = 0; flg_we = 0; xchg_af = 0; xchg_gp = 0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 8; c++) idle_read("R1", 1, 3'(c), 0, 3'(c));

        finish_run();
    end
endmodule